// File: doc/BRIEF.md
# Cascaded Watchdog Timer with Selectable Action

This block watches over a processor by counting down from a reloaded value. Firmware must keep reloading it. If firmware stops doing so, the block raises either a non-maskable interrupt or a hardware reset request. The count chain has two 8-bit down-counters, a low stage and a high stage. In the short mode only the low stage counts and a timeout follows 256 ticks. In the long mode the high stage steps once on each wrap of the low stage, and a timeout follows 65536 ticks. A 5-bit prescale value divides an enabled input clock down to the tick rate.

Software reaches the block through a small synchronous bus with two addresses. Address 0 is the control byte. Address 1 is the status byte, whose bit 0 records a timeout that requested a reset. Writing 1 to that bit clears it. The system reset input returns the control byte and the counters to their initial state but keeps the status flag. Only the pin reset clears the flag, so firmware can tell after the restart that the watchdog caused it.

A three-state controller sequences the block:
- ST_IDLE: the timer is stopped.
- ST_RUN: the timer is counting.
- ST_FIRE: a one-cycle timeout state that drives the chosen output.

The controller moves between these states as follows:
- A control write with the start bit set moves any state to ST_RUN and reloads the counters.
- A control write with the start bit clear moves any state to ST_IDLE.
- ST_RUN moves to ST_FIRE when the selected terminal stage wraps. At the same time the start bit clears.
- ST_FIRE always falls back to ST_IDLE.

Top module: `wdog_cascade`

## Requirements
- R1: After pin reset, the control byte (address 0) reads 0x00, the status byte (address 1) reads 0x00, and neither nmi_o nor wdt_rst_o is asserted.
- R2: A control write with bit 7 = 1 reloads both stages to 0xFF, restarts the prescaler and starts counting, even when the timer is already running. The timeout is then measured from the latest such write.
- R3: A control write with bit 7 = 0 stops the timer. No timeout output appears while it is stopped, and the written byte reads back.
- R4: With bit 5 = 1 (one-byte span), the timeout is seen 1 + 256·(P+1) enabled clocks after the control write edge, where P is bits 4:0. The high stage does not count.
- R5: With bit 5 = 0 (two-byte span), the high stage steps on each low-stage wrap, and the timeout is seen 1 + 65536·(P+1) enabled clocks after the write edge.
- R6: The prescaler gives one tick per P+1 cycles with clk_en high. Cycles with clk_en low are not counted.
- R7: On timeout, exactly one output pulses for exactly one cycle. That output is nmi_o when bit 6 = 1 and wdt_rst_o when bit 6 = 0, and both are never high together.
- R8: A timeout clears control bit 7, leaving the other bits unchanged, and no further timeout follows without a new start write.
- R9: A reset-action timeout sets status bit 0, and an NMI-action timeout does not. Writing status with bit 0 = 1 clears the flag.
- R10: Asserting sys_rst_n clears the control byte and stops the timer but leaves status bit 0 unchanged. pin_rst_n clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pin_rst_n | input | 1 | Active-low pin reset; clears all state including the status flag |
| sys_rst_n | input | 1 | Active-low system reset; clears everything except the status flag |
| clk_en | input | 1 | Count enable feeding the prescaler |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| nmi_o | output | 1 | One-cycle non-maskable interrupt request |
| wdt_rst_o | output | 1 | One-cycle hardware reset request |

## Verification
The scoreboard predicts the exact cycle of each timeout pulse.

Several corner cases are targeted, each with the failure it would expose:
- A second start write while the timer is running. A design that ignores the reload would fire at the first deadline.
- A stop write. A design that keeps counting would produce an unexpected pulse.
- Pauses of clk_en and a nonzero prescale value. An off-by-one prescaler, or one that counts through disabled cycles, would move the pulse.
- The long span. A high stage that counts every tick would fire 256 times too early.
- The idle period after a timeout. A design that does not clear the start bit would fire again.
- A system reset after a reset-action timeout. A design that reset the status flag there would lose the record of the watchdog restart.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wd_state_e;

    // control byte bit positions
    localparam int CTL_START = 7;
    localparam int CTL_NMI   = 6;
    localparam int CTL_ONE   = 5;
    localparam int PSC_W     = 5;

    // register addresses
    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_STS = 1'b1;

endpackage

// File: rtl/wdc_prescaler.sv
module wdc_prescaler #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic [PW-1:0] psc,
    output logic          tick
);
    logic [PW-1:0] cnt_q;

    assign tick = en && !clear && (cnt_q == psc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (en) begin
            if (cnt_q == psc) cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdc_stage.sv
module wdc_stage #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic wrap
);
    logic [W-1:0] cnt_q;

    assign wrap = dec && !load && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '1;
        else if (load) cnt_q <= '1;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/wdc_regs.sv
module wdc_regs
    import wdc_pkg::*;
(
    input  logic       clk,
    input  logic       srst_n,
    input  logic       pin_rst_n,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       clr_start,
    input  logic       set_flag,
    output logic [7:0] ctrl_q,
    output logic       flag_q,
    output logic [7:0] bus_rdata,
    output logic       start_wr,
    output logic       stop_wr
);
    logic ctl_wr;
    logic sts_wr;

    assign ctl_wr   = bus_we && (bus_addr == ADDR_CTL);
    assign sts_wr   = bus_we && (bus_addr == ADDR_STS);
    assign start_wr = ctl_wr &&  bus_wdata[CTL_START];
    assign stop_wr  = ctl_wr && !bus_wdata[CTL_START];

    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
            ctrl_q <= 8'h00;
        end else if (ctl_wr) begin
            ctrl_q <= bus_wdata;
        end else if (clr_start) begin
            ctrl_q[CTL_START] <= 1'b0;
        end
    end

    // survives the system reset; only the pin reset clears it
    always_ff @(posedge clk or negedge pin_rst_n) begin
        if (!pin_rst_n) begin
            flag_q <= 1'b0;
        end else if (set_flag) begin
            flag_q <= 1'b1;
        end else if (sts_wr && bus_wdata[0]) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        if (bus_addr == ADDR_STS) bus_rdata = {7'b0, flag_q};
        else                      bus_rdata = ctrl_q;
    end
endmodule

// File: rtl/wdog_cascade.sv
module wdog_cascade
    import wdc_pkg::*;
#(
    parameter int STAGE_W = 8
) (
    input  logic       clk,
    input  logic       pin_rst_n,
    input  logic       sys_rst_n,
    input  logic       clk_en,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       nmi_o,
    output logic       wdt_rst_o
);
    localparam int NST = 2;

    wd_state_e st_q, st_d;
    logic       srst_n;
    logic [7:0] ctrl_q;
    logic       flag_q;
    logic       start_wr, stop_wr;
    logic       tick;
    logic       timeout;
    logic       clr_start;
    logic       set_flag;
    logic       act_nmi_q;
    logic [NST-1:0] wrap;
    logic [NST-1:0] dec;

    assign srst_n = sys_rst_n & pin_rst_n;

    wdc_regs u_regs (
        .clk       (clk),
        .srst_n    (srst_n),
        .pin_rst_n (pin_rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .clr_start (clr_start),
        .set_flag  (set_flag),
        .ctrl_q    (ctrl_q),
        .flag_q    (flag_q),
        .bus_rdata (bus_rdata),
        .start_wr  (start_wr),
        .stop_wr   (stop_wr)
    );

    wdc_prescaler #(.PW(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (srst_n),
        .clear (start_wr),
        .en    ((st_q == ST_RUN) && clk_en),
        .psc   (ctrl_q[PSC_W-1:0]),
        .tick  (tick)
    );

    for (genvar g = 0; g < NST; g++) begin : g_stage
        if (g == 0) begin : g_low
            assign dec[g] = tick;
        end else begin : g_high
            assign dec[g] = wrap[g-1] && !ctrl_q[CTL_ONE];
        end
        wdc_stage #(.W(STAGE_W)) u_stage (
            .clk   (clk),
            .rst_n (srst_n),
            .load  (start_wr),
            .dec   (dec[g]),
            .wrap  (wrap[g])
        );
    end

    assign timeout   = ctrl_q[CTL_ONE] ? wrap[0] : wrap[NST-1];
    assign clr_start = (st_q == ST_RUN) && timeout && !start_wr && !stop_wr;

    // next-state logic and state register
    always_comb begin
        st_d = st_q;
        if (start_wr) begin
            st_d = ST_RUN;
        end else if (stop_wr) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_RUN:  st_d = timeout ? ST_FIRE : ST_RUN;
                ST_FIRE: st_d = ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
            st_q      <= ST_IDLE;
            act_nmi_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (clr_start) act_nmi_q <= ctrl_q[CTL_NMI];
        end
    end

    // outputs decoded from state
    always_comb begin
        nmi_o     = 1'b0;
        wdt_rst_o = 1'b0;
        set_flag  = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_RUN:  ;
            ST_FIRE: begin
                nmi_o     =  act_nmi_q;
                wdt_rst_o = !act_nmi_q;
                set_flag  = !act_nmi_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wdc_chk.sv
module wdc_chk
    import wdc_pkg::*;
(
    input logic      clk,
    input logic      srst_n,
    input logic      nmi_o,
    input logic      wdt_rst_o,
    input wd_state_e st,
    input logic      ctl_start,
    input logic      flag
);
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!srst_n)
        !(nmi_o && wdt_rst_o)); // R7
    AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!srst_n)
        nmi_o |=> !nmi_o); // R7
    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!srst_n)
        wdt_rst_o |=> !wdt_rst_o); // R7
    AST_STOP_ON_FIRE: assert property (@(posedge clk) disable iff (!srst_n)
        (nmi_o || wdt_rst_o) |-> !ctl_start); // R8
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
        (st != ST_RUN) |=> !(nmi_o || wdt_rst_o)); // R3
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!srst_n)
        wdt_rst_o |=> flag); // R9
    AST_NMI_NO_FLAG: assert property (@(posedge clk) disable iff (!srst_n)
        (nmi_o && !flag) |=> !flag); // R9
endmodule

bind wdog_cascade wdc_chk u_chk (
    .clk       (clk),
    .srst_n    (srst_n),
    .nmi_o     (nmi_o),
    .wdt_rst_o (wdt_rst_o),
    .st        (st_q),
    .ctl_start (ctrl_q[7]),
    .flag      (flag_q)
);

// File: tb/sim_wdog_cascade.sv
module sim_wdog_cascade;
    logic       clk = 1'b0;
    logic       pin_rst_n = 1'b0;
    logic       sys_rst_n = 1'b1;
    logic       clk_en = 1'b1;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       nmi_o, wdt_rst_o;

    always #10 clk = ~clk;

    wdog_cascade u0 (
        .clk(clk), .pin_rst_n(pin_rst_n), .sys_rst_n(sys_rst_n), .clk_en(clk_en),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .nmi_o(nmi_o), .wdt_rst_o(wdt_rst_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    int q_cyc[$];
    bit q_nmi[$];
    bit done = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver: writes a register and predicts any timeout pulse
    task automatic drive(input logic a, input logic [7:0] d, input int pause);
        int span;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        if (a == 1'b0) begin
            q_cyc.delete(); q_nmi.delete();
            if (d[7]) begin
                span = d[5] ? 256 : 65536;
                q_cyc.push_back(cyc + 1 + span * (int'(d[4:0]) + 1) + pause);
                q_nmi.push_back(d[6]);
            end
        end
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares pulses against the expected queue
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (nmi_o && wdt_rst_o) begin
                n_chk++; n_bad++;
                $display("FAIL R7: actual both high expected one");
            end
            if (nmi_o || wdt_rst_o) begin
                if (q_cyc.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R8 R3: actual pulse at %0d expected none", cyc);
                end else begin
                    check("R7 action", int'(nmi_o), int'(q_nmi[0]));
                    check("R4 R5 R6 R2 timing", cyc, q_cyc[0]);
                    void'(q_cyc.pop_front()); void'(q_nmi.pop_front());
                end
            end else if (q_cyc.size() != 0 && cyc > q_cyc[0]) begin
                n_chk++; n_bad++;
                $display("FAIL R4 R5: actual no pulse expected at %0d", q_cyc[0]);
                void'(q_cyc.pop_front()); void'(q_nmi.pop_front());
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        pin_rst_n = 1'b1;
        // R1 reset state
        rd(1'b0, 8'h00, "R1 ctrl");
        rd(1'b1, 8'h00, "R1 status");
        check("R1 outputs", int'(nmi_o | wdt_rst_o), 0);

        // R4 one-byte, NMI action
        drive(1'b0, 8'hE0, 0);
        idle(300);
        rd(1'b0, 8'h60, "R8 start cleared");
        idle(600);                       // R8 no second timeout
        rd(1'b1, 8'h00, "R9 no flag on NMI");

        // R6 prescale 3, reset action
        drive(1'b0, 8'hA3, 0);
        idle(1100);
        rd(1'b1, 8'h01, "R9 flag set");
        rd(1'b0, 8'h23, "R8 ctrl after reset action");
        drive(1'b1, 8'h01, 0);
        rd(1'b1, 8'h00, "R9 flag cleared");

        // R2 reload while running
        drive(1'b0, 8'hA0, 0);
        idle(100);
        drive(1'b0, 8'hA0, 0);
        idle(300);
        drive(1'b1, 8'h01, 0);

        // R3 stop
        drive(1'b0, 8'hA0, 0);
        idle(100);
        drive(1'b0, 8'h20, 0);
        idle(600);
        rd(1'b0, 8'h20, "R3 readback");

        // R6 clk_en pause with prescale 1
        drive(1'b0, 8'hE1, 50);
        idle(100);
        clk_en = 1'b0;
        idle(50);
        clk_en = 1'b1;
        idle(500);

        // R5 two-byte span
        drive(1'b0, 8'hC0, 0);
        idle(65600);
        rd(1'b0, 8'h40, "R8 ctrl after long span");

        // R10 system reset keeps flag
        drive(1'b0, 8'hA0, 0);
        idle(300);
        rd(1'b1, 8'h01, "R9 flag before system reset");
        drive(1'b0, 8'hA0, 0);
        idle(50);
        q_cyc.delete(); q_nmi.delete();
        sys_rst_n = 1'b0;
        idle(3);
        sys_rst_n = 1'b1;
        rd(1'b0, 8'h00, "R10 ctrl cleared");
        rd(1'b1, 8'h01, "R10 flag kept");
        idle(600);                       // R10 timer stopped
        pin_rst_n = 1'b0;
        idle(2);
        pin_rst_n = 1'b1;
        rd(1'b1, 8'h00, "R10 flag cleared by pin");
        check("R2 queue drained", q_cyc.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule